// File: doc/BRIEF.md
# Run-Time Configurable Boxcar Matched Filter

This block sums the most recent Ns input samples on every valid sample, where Ns is the number of samples per symbol. It sits behind a fixed-rate sample source, ahead of a symbol timing recovery stage. A stream of rectangular symbols of length Ns comes out as a triangular wave with its peaks and valleys at the symbol ends. Ns arrives with each sample on a 4-bit port and may change at any sample. The sum is kept as a running accumulator: each sample adds the new input and subtracts the input from Ns samples earlier. That older input is read from an addressable delay line at address Ns-1.

When the effective Ns differs from the value stored with the previous valid sample, the block treats it as a rate change. It pulses a flag for one sample and reloads the accumulator with the present input. For one new period it feeds zero in place of the delayed term, so samples from the old rate cannot leave a DC residue. Beside the filtered sample the block outputs two periods, both as Ns-1: the current one, registered so that it lines up with the filter output, and the one that was in force before the most recent change. Samples are 16-bit signed fixed point with 10 fractional bits (1.0 = 1024).

Top module: `boxcar_mf`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the filter output, rate_new, per_cur and per_prev to 0, and clears the delay line and the stored period. The stored period value 0 matches no legal period, so the first valid sample after reset counts as a rate change.
- R2: When no rate change occurs, out_sample after a valid sample's clock edge equals the previous output plus that sample minus the valid sample Ns samples earlier. In the steady state this is the sum of the last Ns valid inputs, and it appears on the port one cycle after the sample is presented.
- R3: rate_new is high for exactly the one cycle after a valid sample whose effective Ns differs from the stored Ns, and low after every other cycle.
- R4: On a rate-change sample the accumulator is loaded with that sample alone. The delayed term is taken as zero on the change sample and on the next Ns-1 valid samples.
- R5: per_cur shows Ns-1 of the most recent valid sample and is updated on the same edge as out_sample.
- R6: On a rate change per_prev takes the per_cur value that was in force before the change (0 for the first change after reset); at all other times it holds.
- R7: A cycle with in_valid low changes no state: out_sample, per_cur and per_prev hold, rate_new is low, and sps and in_sample are ignored.
- R8: The accumulator is wide enough for 15 full-scale samples. The output saturates to +32767 or -32768 and does not wrap.
- R9: An sps value below 2 is treated as Ns = 2, both for the filter length and for change detection.
- R10: Ns = 15, the largest 4-bit value, is supported: 15 samples of +1.0 give +15.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a cycle that carries a sample |
| in_sample | input | 16 | Signed input sample, 10 fractional bits |
| sps | input | 4 | Samples per symbol Ns (2 to 15) |
| out_sample | output | 16 | Saturated moving sum, same format as the input |
| rate_new | output | 1 | One-cycle flag for a detected rate change |
| per_cur | output | 4 | Ns-1 aligned with out_sample |
| per_prev | output | 4 | Ns-1 in force before the last rate change |

## Verification
The assertions check on every cycle that an idle cycle leaves all outputs unchanged and raises no flag. They also check that the flag only follows a valid sample, that per_prev moves only with the flag and then takes the old per_cur, and that a flagged output equals the reloaded input. The bench scenarios show the arithmetic itself: the triangular sums at two rates, the zero-forced delayed term in the period after a switch, the address Ns-1 at the largest period, saturation in both directions, and the clamping of too-small periods.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_FRAC_W = 10;
    localparam int DEF_NS_W   = 4;
    localparam int DEF_MIN_NS = 2;
endpackage

// File: rtl/boxcar_rate_watch.sv
module boxcar_rate_watch #(
    parameter int NS_W   = 4,
    parameter int MIN_NS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [NS_W-1:0] sps,
    output logic [NS_W-1:0] eff_ns,
    output logic            change,
    output logic            blank,
    output logic            rate_new,
    output logic [NS_W-1:0] per_cur,
    output logic [NS_W-1:0] per_prev
);
    localparam logic [NS_W-1:0] MIN_V = NS_W'(MIN_NS);
    localparam logic [NS_W-1:0] ONE_V = NS_W'(1);

    typedef struct packed {
        logic [NS_W-1:0] stored;
        logic [NS_W-1:0] cur;
        logic [NS_W-1:0] prev;
        logic [NS_W-1:0] cnt;
        logic            flag;
    } watch_t;

    watch_t s_d, s_q;

    always_comb begin
        eff_ns = (sps < MIN_V) ? MIN_V : sps;
        change = in_valid && (eff_ns != s_q.stored);
        blank  = change || (s_q.cnt != '0);

        s_d      = s_q;
        s_d.flag = 1'b0;
        if (in_valid) begin
            s_d.stored = eff_ns;
            s_d.cur    = eff_ns - ONE_V;
            if (change) begin
                s_d.flag = 1'b1;
                s_d.prev = s_q.cur;
                s_d.cnt  = eff_ns - ONE_V;
            end else if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - ONE_V;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rate_new = s_q.flag;
    assign per_cur  = s_q.cur;
    assign per_prev = s_q.prev;
endmodule

// File: rtl/boxcar_delay.sv
module boxcar_delay #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 15,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [DATA_W-1:0] dout
);
    logic signed [DATA_W-1:0] sr_d [DEPTH];
    logic signed [DATA_W-1:0] sr_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!shift_en)   sr_d[i] = sr_q[i];
            else if (i == 0) sr_d[i] = din;
            else             sr_d[i] = sr_q[i-1];
        end
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(addr) == i) dout = sr_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) sr_q[i] <= '0;
            else     sr_q[i] <= sr_d[i];
        end
    end
endmodule

// File: rtl/boxcar_accum.sv
module boxcar_accum #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     reload,
    input  logic signed [DATA_W-1:0] din,
    input  logic signed [DATA_W-1:0] dly,
    output logic signed [DATA_W-1:0] dout
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(64'sd1 <<< (DATA_W-1)));

    logic signed [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (en) begin
            if (reload) acc_d = ACC_W'(din);
            else        acc_d = acc_q + ACC_W'(din) - ACC_W'(dly);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    generate
        if (ACC_W > DATA_W) begin : g_sat
            always_comb begin
                if (acc_q > SAT_HI)      dout = DATA_W'(SAT_HI);
                else if (acc_q < SAT_LO) dout = DATA_W'(SAT_LO);
                else                     dout = DATA_W'(acc_q);
            end
        end else begin : g_pass
            assign dout = DATA_W'(acc_q);
        end
    endgenerate
endmodule

// File: rtl/boxcar_mf.sv
module boxcar_mf
    import boxcar_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int NS_W   = DEF_NS_W,
    parameter int MIN_NS = DEF_MIN_NS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [NS_W-1:0]          sps,
    output logic signed [DATA_W-1:0] out_sample,
    output logic                     rate_new,
    output logic [NS_W-1:0]          per_cur,
    output logic [NS_W-1:0]          per_prev
);
    localparam int MAX_NS = (1 << NS_W) - 1;
    localparam int ACC_W  = DATA_W + NS_W;

    logic [NS_W-1:0]          eff_ns;
    logic                     change;
    logic                     blank;
    logic [NS_W-1:0]          tap_addr;
    logic signed [DATA_W-1:0] tap;
    logic signed [DATA_W-1:0] dly_term;

    boxcar_rate_watch #(.NS_W(NS_W), .MIN_NS(MIN_NS)) u_watch (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sps(sps),
        .eff_ns(eff_ns), .change(change), .blank(blank),
        .rate_new(rate_new), .per_cur(per_cur), .per_prev(per_prev)
    );

    always_comb begin
        tap_addr = eff_ns - NS_W'(1);
        dly_term = blank ? '0 : tap;
    end

    boxcar_delay #(.DATA_W(DATA_W), .DEPTH(MAX_NS), .ADDR_W(NS_W)) u_delay (
        .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_sample),
        .addr(tap_addr), .dout(tap)
    );

    boxcar_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst(rst), .en(in_valid), .reload(change),
        .din(in_sample), .dly(dly_term), .dout(out_sample)
    );
endmodule

// File: rtl/boxcar_mf_chk.sv
module boxcar_mf_chk #(
    parameter int DATA_W = 16,
    parameter int NS_W   = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_sample,
    input logic signed [DATA_W-1:0] out_sample,
    input logic                     rate_new,
    input logic [NS_W-1:0]          per_cur,
    input logic [NS_W-1:0]          per_prev
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(in_valid) |-> ($stable(out_sample) && $stable(per_cur) && $stable(per_prev) && !rate_new));

    p_flag_after_valid_r3: assert property (@(posedge clk) disable iff (rst || !armed_q)
        rate_new |-> $past(in_valid));

    p_reload_value_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        rate_new |-> (out_sample == $past(in_sample)));

    p_prev_takes_old_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        rate_new |-> (per_prev == $past(per_cur)));

    p_prev_moves_on_flag_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (per_prev != $past(per_prev)) |-> rate_new);

    p_cur_moves_on_valid_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (per_cur != $past(per_cur)) |-> $past(in_valid));
endmodule

bind boxcar_mf boxcar_mf_chk #(.DATA_W(DATA_W), .NS_W(NS_W)) u_chk (.*);

// File: tb/sim_boxcar_mf.sv
module sim_boxcar_mf;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic [3:0]         sps = 4'd2;
    logic signed [15:0] out_sample;
    logic               rate_new;
    logic [3:0]         per_cur;
    logic [3:0]         per_prev;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    boxcar_mf u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample), .sps(sps),
        .out_sample(out_sample), .rate_new(rate_new), .per_cur(per_cur), .per_prev(per_prev)
    );

    typedef struct packed {
        logic              v;
        logic [3:0]        ns;
        logic signed [7:0] x;
        logic signed [7:0] e_out;
        logic              e_new;
        logic [3:0]        e_cur;
        logic [3:0]        e_prev;
    } vec_t;

    // x and e_out in units of 1.0 (1024 LSB)
    localparam vec_t TBL [19] = '{
        '{1'b1, 4'd2,  8'sd1,  8'sd1, 1'b1, 4'd1, 4'd0},  // first after reset (R3, R6)
        '{1'b1, 4'd2,  8'sd1,  8'sd2, 1'b0, 4'd1, 4'd0},  // zero-forced term (R4)
        '{1'b1, 4'd2, -8'sd1,  8'sd0, 1'b0, 4'd1, 4'd0},
        '{1'b1, 4'd2, -8'sd1, -8'sd2, 1'b0, 4'd1, 4'd0},
        '{1'b1, 4'd2,  8'sd1,  8'sd0, 1'b0, 4'd1, 4'd0},
        '{1'b1, 4'd2,  8'sd1,  8'sd2, 1'b0, 4'd1, 4'd0},
        '{1'b1, 4'd3, -8'sd1, -8'sd1, 1'b1, 4'd2, 4'd1},  // switch 2->3, reload (R4)
        '{1'b1, 4'd3, -8'sd1, -8'sd2, 1'b0, 4'd2, 4'd1},
        '{1'b1, 4'd3,  8'sd1, -8'sd1, 1'b0, 4'd2, 4'd1},
        '{1'b1, 4'd3,  8'sd1,  8'sd1, 1'b0, 4'd2, 4'd1},
        '{1'b1, 4'd3,  8'sd1,  8'sd3, 1'b0, 4'd2, 4'd1},
        '{1'b1, 4'd3, -8'sd1,  8'sd1, 1'b0, 4'd2, 4'd1},
        '{1'b0, 4'd3,  8'sd5,  8'sd1, 1'b0, 4'd2, 4'd1},  // idle, junk sample (R7)
        '{1'b1, 4'd3, -8'sd1, -8'sd1, 1'b0, 4'd2, 4'd1},
        '{1'b0, 4'd5,  8'sd3, -8'sd1, 1'b0, 4'd2, 4'd1},  // idle, other sps (R7)
        '{1'b1, 4'd3, -8'sd1, -8'sd3, 1'b0, 4'd2, 4'd1},
        '{1'b1, 4'd2,  8'sd1,  8'sd1, 1'b1, 4'd1, 4'd2},  // switch 3->2
        '{1'b1, 4'd2,  8'sd1,  8'sd2, 1'b0, 4'd1, 4'd2},
        '{1'b1, 4'd2, -8'sd1,  8'sd0, 1'b0, 4'd1, 4'd2}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] ns, input logic signed [15:0] x);
        @(negedge clk);
        in_valid  = v;
        sps       = ns;
        in_sample = x;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic signed [15:0] units(input int u);
        return 16'(u * 1024);
    endfunction

    initial begin
        do_reset();
        chk("R1 out after reset", int'(out_sample), 0);
        chk("R1 flag after reset", int'(rate_new), 0);
        chk("R1 per_cur after reset", int'(per_cur), 0);
        chk("R1 per_prev after reset", int'(per_prev), 0);

        for (int i = 0; i < 19; i++) begin
            step(TBL[i].v, TBL[i].ns, units(int'(TBL[i].x)));
            chk($sformatf("R2/R4/R7 out vec %0d", i), int'(out_sample), int'(units(int'(TBL[i].e_out))));
            chk($sformatf("R3 flag vec %0d", i), int'(rate_new), int'(TBL[i].e_new));
            chk($sformatf("R5 per_cur vec %0d", i), int'(per_cur), int'(TBL[i].e_cur));
            chk($sformatf("R6 per_prev vec %0d", i), int'(per_prev), int'(TBL[i].e_prev));
        end
        step(1'b0, 4'd2, '0);
        chk("R3 flag low on idle after change", int'(rate_new), 0);

        // R1: reset after activity clears state
        do_reset();
        chk("R1 out cleared", int'(out_sample), 0);
        chk("R1 per_prev cleared", int'(per_prev), 0);

        // R10: largest period
        for (int i = 0; i < 15; i++) step(1'b1, 4'd15, units(1));
        chk("R10 sum of 15", int'(out_sample), int'(units(15)));
        chk("R10 per_cur", int'(per_cur), 14);
        step(1'b1, 4'd15, units(-1));
        chk("R10 tap at address 14", int'(out_sample), int'(units(13)));

        // R9: too-small period clamps to 2
        do_reset();
        step(1'b1, 4'd0, units(1));
        chk("R9 flag on clamped first", int'(rate_new), 1);
        chk("R9 per_cur clamped", int'(per_cur), 1);
        step(1'b1, 4'd1, units(1));
        chk("R9 sps 1 same as 2, no flag", int'(rate_new), 0);
        chk("R9 out", int'(out_sample), int'(units(2)));
        step(1'b1, 4'd2, units(1));
        chk("R9 sps 2 no flag", int'(rate_new), 0);
        chk("R9 length two sum", int'(out_sample), int'(units(2)));

        // R8: saturation both ways
        do_reset();
        step(1'b1, 4'd4, 16'sh7FFF);
        step(1'b1, 4'd4, 16'sh7FFF);
        chk("R8 positive saturation", int'(out_sample), 32767);
        step(1'b1, 4'd4, 16'sh7FFF);
        chk("R8 positive saturation held", int'(out_sample), 32767);
        do_reset();
        step(1'b1, 4'd4, -16'sh8000);
        step(1'b1, 4'd4, -16'sh8000);
        chk("R8 negative saturation", int'(out_sample), -32768);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule